// File: doc/BRIEF.md
# Parallel Slave Port

This block lets an external microprocessor read and write one 8-bit data latch through a chip select, a read strobe and a write strobe, all active low. The same latch is shared with an internal host bus. The external strobes arrive with no relation to the internal clock. They pass through synchronisers, and the block frames a transaction from the combined level of chip select and strobe. A transaction starts on the first sampled cycle in which both are low. It ends on the first sampled cycle in which either one has returned high.

While an external read is in progress, the block drives the latch onto the data bus through an output enable. At the end of an external write, the value the bus held on the last sampled cycle of the write is taken into the latch. Three flags tell the internal side what has happened: input full, output full, and an interrupt flag that stays set until it is cleared. The port works only while its enable bit is set and the conflicting multi-output PWM mode is off. In any other case the strobes are ignored and the bus stays released.

Top module: `pport_slave`

## Requirements
- R1: After reset the latch reads 0x00, in_full, out_full and irq_flag are 0, and bus_oe is 0.
- R2: An external write (ext_cs_n and ext_wr_n both low, then either one high) loads the latch with the bus_in value sampled on the last cycle before the end, and sets in_full and irq_flag.
- R3: During an external read (ext_cs_n and ext_rd_n low) bus_oe is 1 and bus_out carries the latch. When either line returns high, bus_oe drops to 0, irq_flag is set and out_full is cleared.
- R4: A host_wr outside an external read loads host_wdata into the latch and sets out_full.
- R5: A host_wr during an external read puts the new value on bus_out on the next cycle and leaves out_full unchanged.
- R6: host_rd clears in_full and irq_clr clears irq_flag. A flag that is being set in the same cycle stays set.
- R7: While port_en is 0 or pwm_multi is 1, the external strobes are ignored: bus_oe stays 0, no flag is set and the latch is unchanged.
- R8: With ext_cs_n, ext_rd_n and ext_wr_n all low together, the transaction is a write: bus_oe stays 0 and the write completes as in R2.
- R9: Strobe synchronisation uses two flops. bus_oe is 0 after the second rising edge following the strobes going low and is 1 after the third.
- R10: Leaving port mode in the middle of a transaction aborts it: bus_oe drops and no flag is set.
- R11: With ext_cs_n high, activity on ext_wr_n or ext_rd_n has no effect on the latch, the flags or bus_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Enables parallel port mode |
| pwm_multi | input | 1 | Conflicting multi-output PWM mode is on; disables the port |
| ext_cs_n | input | 1 | External chip select, active low |
| ext_rd_n | input | 1 | External read strobe, active low |
| ext_wr_n | input | 1 | External write strobe, active low |
| bus_in | input | 8 | Data bus value seen at the pins |
| bus_out | output | 8 | Data driven onto the bus |
| bus_oe | output | 1 | Output enable for the bus drivers |
| host_wr | input | 1 | Internal write of the latch |
| host_wdata | input | 8 | Internal write data |
| host_rd | input | 1 | Internal read of the latch (clears in_full) |
| irq_clr | input | 1 | Clears irq_flag |
| latch_q | output | 8 | Current latch contents |
| in_full | output | 1 | External write has delivered data |
| out_full | output | 1 | Internal data is waiting for an external read |
| irq_flag | output | 1 | Set at the end of each external transaction |

## Verification
The hardest case to reach is an internal write that lands while an external read is held open. The new value must reach the bus at once, yet the output-full flag must not move. The bench gets there by holding chip select and the read strobe low for several cycles, checking that the bus is enabled, and only then pulsing host_wr. It checks bus_out on the next cycle and out_full before the strobe is released. Two other sequences are also built on purpose: changing bus_in partway through a write, to show which sample is kept, and dropping port_en inside a read, to show that the read aborts.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int PP_DW       = 8;
    localparam int PP_SYNC_STG = 2;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_WRITE = 2'd1,
        PS_READ  = 2'd2
    } pp_state_e;

    typedef struct packed {
        logic cs_n;
        logic rd_n;
        logic wr_n;
    } pp_strobe_t;

    typedef struct packed {
        logic wr_done;
        logic rd_done;
        logic rd_busy;
    } pp_event_t;

    // write request: select and write strobe both low
    function automatic logic pp_wr_req(pp_strobe_t s);
        return !s.cs_n && !s.wr_n;
    endfunction

    // read request: select and read strobe low, write not competing
    function automatic logic pp_rd_req(pp_strobe_t s);
        return !s.cs_n && !s.rd_n && s.wr_n;
    endfunction

    // read stays open while select and read strobe are low
    function automatic logic pp_rd_hold(pp_strobe_t s);
        return !s.cs_n && !s.rd_n;
    endfunction

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
    import pport_pkg::*;
#(
    parameter int DW = PP_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  pp_strobe_t    strb,
    input  logic [DW-1:0] din,
    output pp_event_t     ev,
    output logic [DW-1:0] cap
);
    pp_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_IDLE;
            cap   <= '0;
        end else if (!active) begin
            state <= PS_IDLE;
        end else begin
            unique case (state)
                PS_IDLE: begin
                    if (pp_wr_req(strb)) begin
                        state <= PS_WRITE;
                        cap   <= din;
                    end else if (pp_rd_req(strb)) begin
                        state <= PS_READ;
                    end
                end
                PS_WRITE: begin
                    if (pp_wr_req(strb)) cap   <= din;
                    else                 state <= PS_IDLE;
                end
                PS_READ: begin
                    if (!pp_rd_hold(strb)) state <= PS_IDLE;
                end
                default: state <= PS_IDLE;
            endcase
        end
    end

    always_comb begin
        ev.wr_done = active && (state == PS_WRITE) && !pp_wr_req(strb);
        ev.rd_done = active && (state == PS_READ)  && !pp_rd_hold(strb);
        ev.rd_busy = (state == PS_READ);
    end
endmodule

// File: rtl/pport_flags.sv
module pport_flags
    import pport_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pp_event_t ev,
    input  logic      host_wr,
    input  logic      host_rd,
    input  logic      irq_clr,
    output logic      ibf,
    output logic      obf,
    output logic      irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ibf <= 1'b0;
            obf <= 1'b0;
            irq <= 1'b0;
        end else begin
            if (ev.wr_done)    ibf <= 1'b1;
            else if (host_rd)  ibf <= 1'b0;

            if (ev.rd_done)                     obf <= 1'b0;
            else if (host_wr && !ev.rd_busy)    obf <= 1'b1;

            if (ev.wr_done || ev.rd_done) irq <= 1'b1;
            else if (irq_clr)             irq <= 1'b0;
        end
    end
endmodule

// File: rtl/pport_slave.sv
module pport_slave
    import pport_pkg::*;
#(
    parameter int DW      = PP_DW,
    parameter int SYNC_ST = PP_SYNC_STG
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          port_en,
    input  logic          pwm_multi,
    input  logic          ext_cs_n,
    input  logic          ext_rd_n,
    input  logic          ext_wr_n,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_rd,
    input  logic          irq_clr,
    output logic [DW-1:0] latch_q,
    output logic          in_full,
    output logic          out_full,
    output logic          irq_flag
);
    localparam int SW = $bits(pp_strobe_t);

    pp_strobe_t    strb_raw, strb_s;
    logic [DW-1:0] din_s, cap;
    pp_event_t     ev;
    logic [DW-1:0] latch;
    logic          active;

    assign strb_raw = '{cs_n: ext_cs_n, rd_n: ext_rd_n, wr_n: ext_wr_n};
    assign active   = port_en && !pwm_multi;

    pport_sync #(.W(SW), .STAGES(SYNC_ST), .RST_VAL({SW{1'b1}})) u_sync_strb (
        .clk(clk), .rst(rst), .d(strb_raw), .q(strb_s)
    );

    pport_sync #(.W(DW), .STAGES(SYNC_ST), .RST_VAL('0)) u_sync_data (
        .clk(clk), .rst(rst), .d(bus_in), .q(din_s)
    );

    pport_ctrl #(.DW(DW)) u_ctrl (
        .clk(clk), .rst(rst), .active(active), .strb(strb_s),
        .din(din_s), .ev(ev), .cap(cap)
    );

    pport_flags u_flags (
        .clk(clk), .rst(rst), .ev(ev), .host_wr(host_wr),
        .host_rd(host_rd), .irq_clr(irq_clr),
        .ibf(in_full), .obf(out_full), .irq(irq_flag)
    );

    always_ff @(posedge clk) begin
        if (rst)             latch <= '0;
        else if (host_wr)    latch <= host_wdata;
        else if (ev.wr_done) latch <= cap;
    end

    assign latch_q = latch;
    assign bus_out = latch;
    assign bus_oe  = ev.rd_busy;
endmodule

// File: rtl/pport_slave_chk.sv
module pport_slave_chk (
    input logic clk,
    input logic rst,
    input logic port_en,
    input logic pwm_multi,
    input logic bus_oe,
    input logic host_wr,
    input logic host_rd,
    input logic in_full,
    input logic out_full,
    input logic irq_flag,
    input logic wr_done
);
    logic active;
    assign active = port_en && !pwm_multi;

    p_idle_off_r7: assert property (@(posedge clk) disable iff (rst)
        !active |=> !bus_oe);

    p_write_flags_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(in_full) |-> irq_flag);

    p_hostrd_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !wr_done) |=> !in_full);

    p_read_keep_obf_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && host_wr && !out_full) |=> !out_full);

    p_read_end_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_oe) && $past(active)) |-> (irq_flag && !out_full));
endmodule

bind pport_slave pport_slave_chk u_chk (
    .clk(clk), .rst(rst), .port_en(port_en), .pwm_multi(pwm_multi),
    .bus_oe(bus_oe), .host_wr(host_wr), .host_rd(host_rd),
    .in_full(in_full), .out_full(out_full), .irq_flag(irq_flag),
    .wr_done(ev.wr_done)
);

// File: tb/pport_slave_test.sv
module pport_slave_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       port_en = 1'b1, pwm_multi = 1'b0;
    logic       ext_cs_n = 1'b1, ext_rd_n = 1'b1, ext_wr_n = 1'b1;
    logic [7:0] bus_in = '0, host_wdata = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0, irq_clr = 1'b0;
    logic [7:0] bus_out, latch_q;
    logic       bus_oe, in_full, out_full, irq_flag;
    int         n_chk = 0, n_err = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    pport_slave uut (.*);

    localparam logic [7:0] WR_VEC [6] = '{8'h3C, 8'hFF, 8'h00, 8'h81, 8'h7E, 8'hA4};

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_hw(logic [7:0] d);
        host_wdata = d; host_wr = 1'b1; tick(1); host_wr = 1'b0;
    endtask

    task automatic pulse_rd();
        host_rd = 1'b1; tick(1); host_rd = 1'b0;
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
    endtask

    task automatic ext_write(logic [7:0] d);
        bus_in = d; ext_cs_n = 1'b0; ext_wr_n = 1'b0; tick(4);
        ext_wr_n = 1'b1; ext_cs_n = 1'b1; tick(4);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk("R1 latch", latch_q, 8'h00);
        chk("R1 flags", {in_full, out_full, irq_flag}, 3'b000);
        chk("R1 oe", bus_oe, 1'b0);

        // R2 / R6 table walk
        foreach (WR_VEC[i]) begin
            ext_write(WR_VEC[i]);
            chk("R2 latch", latch_q, WR_VEC[i]);
            chk("R2 ibf+irq", {in_full, irq_flag}, 2'b11);
            pulse_rd();
            chk("R6 ibf clear", in_full, 1'b0);
            pulse_clr();
            chk("R6 irq clear", irq_flag, 1'b0);
        end

        // R2 last sample kept
        bus_in = 8'h11; ext_cs_n = 1'b0; ext_wr_n = 1'b0; tick(4);
        bus_in = 8'h22; tick(4);
        ext_wr_n = 1'b1; tick(4); ext_cs_n = 1'b1;
        chk("R2 last sample", latch_q, 8'h22);
        pulse_rd(); pulse_clr();

        // R4 host write
        pulse_hw(8'h5A);
        chk("R4 latch", latch_q, 8'h5A);
        chk("R4 obf", out_full, 1'b1);

        // R9 latency, R3 read, R5 host write during read
        ext_cs_n = 1'b0; ext_rd_n = 1'b0;
        tick(2);
        chk("R9 oe after two edges", bus_oe, 1'b0);
        tick(1);
        chk("R9 oe after three edges", bus_oe, 1'b1);
        chk("R3 bus data", bus_out, 8'h5A);
        pulse_hw(8'hA5);
        chk("R5 bus updated", bus_out, 8'hA5);
        chk("R5 obf unchanged", out_full, 1'b1);
        tick(2);
        ext_rd_n = 1'b1; tick(4); ext_cs_n = 1'b1;
        chk("R3 oe released", bus_oe, 1'b0);
        chk("R3 irq set", irq_flag, 1'b1);
        chk("R3 obf cleared", out_full, 1'b0);
        pulse_clr();

        // R11 chip select high
        bus_in = 8'h33; ext_wr_n = 1'b0; tick(5); ext_wr_n = 1'b1;
        ext_rd_n = 1'b0; tick(3);
        chk("R11 oe", bus_oe, 1'b0);
        ext_rd_n = 1'b1; tick(4);
        chk("R11 latch", latch_q, 8'hA5);
        chk("R11 flags", {in_full, irq_flag}, 2'b00);

        // R7 disabled by port_en and pwm_multi
        port_en = 1'b0;
        ext_write(8'h44);
        chk("R7 latch en", latch_q, 8'hA5);
        chk("R7 flags en", {in_full, irq_flag}, 2'b00);
        port_en = 1'b1; pwm_multi = 1'b1;
        ext_cs_n = 1'b0; ext_rd_n = 1'b0; tick(5);
        chk("R7 oe pwm", bus_oe, 1'b0);
        ext_cs_n = 1'b1; ext_rd_n = 1'b1; tick(4);
        chk("R7 irq pwm", irq_flag, 1'b0);
        pwm_multi = 1'b0; tick(2);

        // R8 write priority
        bus_in = 8'h66; ext_cs_n = 1'b0; ext_rd_n = 1'b0; ext_wr_n = 1'b0; tick(5);
        chk("R8 oe low", bus_oe, 1'b0);
        ext_cs_n = 1'b1; ext_rd_n = 1'b1; ext_wr_n = 1'b1; tick(4);
        chk("R8 write done", {latch_q, in_full}, {8'h66, 1'b1});
        pulse_rd(); pulse_clr();

        // R10 abort
        ext_cs_n = 1'b0; ext_rd_n = 1'b0; tick(4);
        chk("R10 oe before", bus_oe, 1'b1);
        port_en = 1'b0; tick(2);
        chk("R10 oe aborted", bus_oe, 1'b0);
        ext_cs_n = 1'b1; ext_rd_n = 1'b1; tick(4);
        chk("R10 no irq", irq_flag, 1'b0);
        port_en = 1'b1; tick(2);

        // R6 set wins over clear
        ext_cs_n = 1'b0; ext_wr_n = 1'b0; bus_in = 8'h77; tick(4);
        ext_wr_n = 1'b1; tick(2);
        host_rd = 1'b1; irq_clr = 1'b1; tick(1);
        host_rd = 1'b0; irq_clr = 1'b0; ext_cs_n = 1'b1; tick(1);
        chk("R6 set wins", {in_full, irq_flag}, 2'b11);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule